// File: doc/BRIEF.md
# NAND Target Command Front End

This block is the device side of an 8-bit multiplexed NAND bus. It oversamples the host strobes on the system clock. A rising write strobe with the chip enable low becomes a command, address or data event, and a falling read strobe becomes a read event. A small mode machine decides what each read returns: identification bytes, parameter-page bytes, a status byte, or bytes from a page buffer RAM. A column pointer advances on every read strobe and on every data byte that is loaded.

Program and erase sequences are modelled only as far as the host can see them. They load the page buffer, hold the ready line low for a fixed number of clocks, and record a pass or fail flag. A low write-protect input refuses them. Identification mode is sticky: a status request issued while in it is ignored until some other command, typically 00h, has been written first. A configuration input selects between the two identification byte sets, one for a single die or separate enables and one for two dies behind one enable.

Top module: `nand_cmd_frontend`

## Requirements
- R1: With `cs_n` low, a rising `we_n` captures `din` as a command when `cle`=1 and `ale`=0, as an address when `ale`=1 and `cle`=0, and as data when both are 0. Strobes with `cs_n` high have no effect.
- R2: Command 90h followed by address 00h enters identification mode with the pointer at 0. Five reads then return the identification bytes, and any later read returns 00h.
- R3: With `id_cfg`=0 the identification bytes are 01h, DCh, 90h, 95h, 54h. With `id_cfg`=1 they are 01h, D3h, D1h, 95h, 58h.
- R4: Each falling `re_n` with `cs_n` low updates `dout` one clock later and steps the column pointer by one. `oe` is high only in the clock after a cycle with `cs_n` low and `re_n` low.
- R5: In identification mode a 70h command is ignored and reads continue the identification sequence. After a 00h command, 70h selects status.
- R6: Command ECh followed by address 00h streams parameter bytes from offset 0, repeating every 256 bytes. The bytes are 4Fh, 4Eh, 46h, 49h at offsets 0 to 3; 02h at 4; 01h at 64; 08h at 81; 40h at 92; and 00h everywhere else.
- R7: After 70h, reads return a status byte with bit 7 = `wp_n`, bit 6 = ready, bit 0 = fail flag, and bits 5 to 1 = 0.
- R8: 80h, a column address, data bytes, then 10h writes the data into the page buffer from that column and drops `rdy` for BUSY_CYC clocks. 00h, a column address and 30h then read the buffer back from that column.
- R9: With `wp_n` low, 80h, 10h, 60h and D0h are refused. The fail flag is set, `rdy` stays high and the buffer is unchanged.
- R10: 60h, any address bytes, then D0h with `wp_n` high drops `rdy` for BUSY_CYC clocks and clears the fail flag.
- R11: Reset, or command FFh, returns the block to idle, where reads return FFh. After reset `oe`=0, `rdy`=1 and the fail flag is 0.
- R12: While `rdy` is low, every command except 70h is ignored, and address and data bytes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus strobes |
| rst | input | 1 | Synchronous active-high reset |
| id_cfg | input | 1 | Selects the identification byte set |
| cs_n | input | 1 | Chip enable, active low |
| cle | input | 1 | Marks a command cycle |
| ale | input | 1 | Marks an address cycle |
| we_n | input | 1 | Write strobe; rising edge captures `din` |
| re_n | input | 1 | Read strobe; falling edge fetches the next byte |
| wp_n | input | 1 | Write protect, active low |
| din | input | 8 | Host-to-target bus byte |
| dout | output | 8 | Target-to-host bus byte |
| oe | output | 1 | Output enable for `dout` |
| rdy | output | 1 | Ready, low while a program or erase is in progress |

## Verification
The assertions assume that the host strobes are synchronous to `clk` and held for at least two clocks. They also assume that a write edge and a read edge never fall in the same clock, so the pointer has only one cause to move in any cycle. The stimulus changes inputs only on the falling clock edge and holds each strobe level for two clocks. It finishes each write strobe before starting a read strobe, and it drops `cle` and `ale` only after `we_n` has returned high. It reads buffer locations only after they have been written.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  typedef enum logic [3:0] {
    M_IDLE, M_ID_ADR, M_ID, M_PP_ADR, M_PARAM, M_STATUS,
    M_RD_ADR, M_READ, M_PROG, M_ERS_ADR
  } mode_e;

  localparam logic [7:0] OP_READ   = 8'h00;
  localparam logic [7:0] OP_RDGO   = 8'h30;
  localparam logic [7:0] OP_LOAD   = 8'h80;
  localparam logic [7:0] OP_PGO    = 8'h10;
  localparam logic [7:0] OP_ERS    = 8'h60;
  localparam logic [7:0] OP_EGO    = 8'hD0;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PARAM  = 8'hEC;
  localparam logic [7:0] OP_RESET  = 8'hFF;

  function automatic logic [7:0] id_byte(input logic cfg, input logic [7:0] idx);
    logic [7:0] b;
    case (idx)
      8'd0:    b = 8'h01;
      8'd1:    b = cfg ? 8'hD3 : 8'hDC;
      8'd2:    b = cfg ? 8'hD1 : 8'h90;
      8'd3:    b = 8'h95;
      8'd4:    b = cfg ? 8'h58 : 8'h54;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

  function automatic logic [7:0] pp_byte(input logic [7:0] off);
    logic [7:0] b;
    case (off)
      8'd0:    b = 8'h4F;
      8'd1:    b = 8'h4E;
      8'd2:    b = 8'h46;
      8'd3:    b = 8'h49;
      8'd4:    b = 8'h02;
      8'd64:   b = 8'h01;
      8'd81:   b = 8'h08;
      8'd92:   b = 8'h40;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic cle,
  input  logic ale,
  input  logic we_n,
  input  logic re_n,
  output logic cmd_ev,
  output logic addr_ev,
  output logic data_ev,
  output logic rd_ev
);
  logic we_q, re_q, we_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      we_q <= 1'b1;
      re_q <= 1'b1;
    end else begin
      we_q <= we_n;
      re_q <= re_n;
    end
  end

  assign we_rise = !cs_n && !we_q && we_n;
  assign cmd_ev  = we_rise && cle && !ale;
  assign addr_ev = we_rise && ale && !cle;
  assign data_ev = we_rise && !cle && !ale;
  assign rd_ev   = !cs_n && re_q && !re_n;

endmodule

// File: rtl/nand_busy_timer.sv
module nand_busy_timer #(
  parameter int CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= CW'(CYC);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  AST_BUSY_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (busy && !load) |=> cnt == CW'($past(cnt) - 1'b1)); // R8

endmodule

// File: rtl/nand_page_buf.sv
module nand_page_buf #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nand_fe_pkg::*;
#(
  parameter int PAGE_BYTES = 64,
  parameter int BUSY_CYC   = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       id_cfg,
  input  logic       cs_n,
  input  logic       cle,
  input  logic       ale,
  input  logic       we_n,
  input  logic       re_n,
  input  logic       wp_n,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       oe,
  output logic       rdy
);
  localparam int AW    = $clog2(PAGE_BYTES);
  localparam int PTR_W = (AW > 8) ? AW : 8;

  logic cmd_ev, addr_ev, data_ev, rd_ev;
  logic busy, busy_load, buf_wr;
  logic [7:0] buf_q;
  logic [PTR_W-1:0] ptr;
  logic fail;
  mode_e mode;

  nand_bus_decode i_dec (
    .clk(clk), .rst(rst), .cs_n(cs_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n),
    .cmd_ev(cmd_ev), .addr_ev(addr_ev), .data_ev(data_ev), .rd_ev(rd_ev)
  );

  nand_busy_timer #(.CYC(BUSY_CYC)) i_busy (
    .clk(clk), .rst(rst), .load(busy_load), .busy(busy)
  );

  nand_page_buf #(.DEPTH(PAGE_BYTES)) i_buf (
    .clk(clk), .wr(buf_wr), .waddr(ptr[AW-1:0]), .wdata(din),
    .raddr(ptr[AW-1:0]), .rdata(buf_q)
  );

  assign buf_wr    = data_ev && !busy && (mode == M_PROG);
  assign busy_load = cmd_ev && !busy && wp_n &&
                     ((din == OP_PGO && mode == M_PROG) ||
                      (din == OP_EGO && mode == M_ERS_ADR));
  assign rdy = !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= M_IDLE;
      ptr  <= '0;
      fail <= 1'b0;
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      oe <= !cs_n && !re_n;
      if (rd_ev) begin
        case (mode)
          M_ID:     dout <= id_byte(id_cfg, ptr[7:0]);
          M_PARAM:  dout <= pp_byte(ptr[7:0]);
          M_STATUS: dout <= {wp_n, !busy, 5'b0, fail};
          M_READ:   dout <= buf_q;
          default:  dout <= 8'hFF;
        endcase
        ptr <= ptr + 1'b1;
      end
      if (cmd_ev && (!busy || din == OP_STATUS)) begin
        case (din)
          OP_STATUS: if (mode != M_ID) mode <= M_STATUS;
          OP_IDENT:  mode <= M_ID_ADR;
          OP_PARAM:  mode <= M_PP_ADR;
          OP_READ:   mode <= M_RD_ADR;
          OP_RDGO:   mode <= (mode == M_RD_ADR) ? M_READ : M_IDLE;
          OP_LOAD: begin
            mode <= wp_n ? M_PROG : M_IDLE;
            if (!wp_n) fail <= 1'b1;
          end
          OP_ERS: begin
            mode <= wp_n ? M_ERS_ADR : M_IDLE;
            if (!wp_n) fail <= 1'b1;
          end
          OP_PGO, OP_EGO: begin
            if ((din == OP_PGO && mode == M_PROG) ||
                (din == OP_EGO && mode == M_ERS_ADR))
              fail <= !wp_n;
            mode <= M_IDLE;
          end
          default:   mode <= M_IDLE;
        endcase
      end
      if (addr_ev && !busy) begin
        case (mode)
          M_ID_ADR: begin
            mode <= (din == 8'h00) ? M_ID : M_IDLE;
            ptr  <= '0;
          end
          M_PP_ADR: begin
            mode <= (din == 8'h00) ? M_PARAM : M_IDLE;
            ptr  <= '0;
          end
          M_RD_ADR, M_PROG: ptr <= PTR_W'(din);
          default: ;
        endcase
      end
      if (buf_wr) ptr <= ptr + 1'b1;
    end
  end

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> !oe); // R4
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    (rd_ev && !cmd_ev && !addr_ev && !data_ev) |=> ptr == PTR_W'($past(ptr) + 1'b1)); // R4
  AST_ID_KEEPS_ON_STATUS: assert property (@(posedge clk) disable iff (rst)
    (cmd_ev && mode == M_ID && din == OP_STATUS) |=> mode == M_ID); // R5
  AST_WP_BLOCKS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_ev && !wp_n && !busy) |=> !busy); // R9
  AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (rst)
    (cmd_ev && busy && din != OP_STATUS) |=> mode == $past(mode)); // R12
  AST_PROT_SETS_FAIL: assert property (@(posedge clk) disable iff (rst)
    (cmd_ev && !busy && !wp_n && (din == OP_LOAD || din == OP_ERS)) |=> fail); // R9

endmodule

// File: tb/test_nand_cmd_frontend.sv
module test_nand_cmd_frontend;
  localparam int BUSY = 32;
  localparam int PB   = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic id_cfg = 1'b0, cs_n = 1'b0, cle = 1'b0, ale = 1'b0;
  logic we_n = 1'b1, re_n = 1'b1, wp_n = 1'b1;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic oe, rdy;

  always #10 clk = ~clk;

  nand_cmd_frontend #(.PAGE_BYTES(PB), .BUSY_CYC(BUSY)) i_nand_cmd_frontend (
    .clk(clk), .rst(rst), .id_cfg(id_cfg), .cs_n(cs_n), .cle(cle), .ale(ale),
    .we_n(we_n), .re_n(re_n), .wp_n(wp_n), .din(din),
    .dout(dout), .oe(oe), .rdy(rdy)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0, cmp_on = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  localparam int S_IDLE = 0, S_IDA = 1, S_ID = 2, S_PPA = 3, S_PP = 4,
                 S_ST = 5, S_RDA = 6, S_RD = 7, S_PG = 8, S_ERA = 9;
  int m_mode, m_ptr, m_cnt, m_dout;
  bit m_fail, m_oe;
  int m_mem [PB];
  bit pwe, pre;
  int id_tab [2][5] = '{'{8'h01, 8'hDC, 8'h90, 8'h95, 8'h54},
                        '{8'h01, 8'hD3, 8'hD1, 8'h95, 8'h58}};

  function automatic int exp_param(input int off);
    int o = off % 256;
    if (o < 4) return (o == 0) ? 'h4F : (o == 1) ? 'h4E : (o == 2) ? 'h46 : 'h49;
    if (o == 4)  return 'h02;
    if (o == 64) return 'h01;
    if (o == 81) return 'h08;
    if (o == 92) return 'h40;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit sel, wr_edge, ce, ae, de, re, bsy, ld;
    if (rst) begin
      m_mode = S_IDLE; m_ptr = 0; m_cnt = 0; m_dout = 0; m_fail = 0; m_oe = 0;
      pwe = 1; pre = 1;
    end else begin
      sel = !cs_n;
      wr_edge = sel && !pwe && we_n;
      ce = wr_edge && cle && !ale;
      ae = wr_edge && ale && !cle;
      de = wr_edge && !cle && !ale;
      re = sel && pre && !re_n;
      bsy = (m_cnt != 0);
      ld = 0;
      if (re) begin
        if (m_mode == S_ID)      m_dout = (m_ptr < 5) ? id_tab[id_cfg][m_ptr] : 0;
        else if (m_mode == S_PP) m_dout = exp_param(m_ptr);
        else if (m_mode == S_ST) m_dout = (wp_n << 7) | ((!bsy) << 6) | m_fail;
        else if (m_mode == S_RD) m_dout = m_mem[m_ptr % PB];
        else                     m_dout = 'hFF;
        m_ptr = (m_ptr + 1) % 256;
      end
      if (ce && (!bsy || din == 8'h70)) begin
        if (din == 8'h70) begin
          if (m_mode != S_ID) m_mode = S_ST;
        end else if (din == 8'h90) m_mode = S_IDA;
        else if (din == 8'hEC) m_mode = S_PPA;
        else if (din == 8'h00) m_mode = S_RDA;
        else if (din == 8'h30) m_mode = (m_mode == S_RDA) ? S_RD : S_IDLE;
        else if (din == 8'h80 || din == 8'h60) begin
          if (wp_n) m_mode = (din == 8'h80) ? S_PG : S_ERA;
          else begin m_mode = S_IDLE; m_fail = 1; end
        end else if (din == 8'h10 || din == 8'hD0) begin
          if ((din == 8'h10 && m_mode == S_PG) || (din == 8'hD0 && m_mode == S_ERA)) begin
            m_fail = !wp_n;
            ld = wp_n;
          end
          m_mode = S_IDLE;
        end else m_mode = S_IDLE;
      end
      if (ae && !bsy) begin
        if (m_mode == S_IDA || m_mode == S_PPA) begin
          m_mode = (din != 0) ? S_IDLE : (m_mode == S_IDA) ? S_ID : S_PP;
          m_ptr = 0;
        end else if (m_mode == S_RDA || m_mode == S_PG) m_ptr = din;
      end
      if (de && !bsy && m_mode == S_PG) begin
        m_mem[m_ptr % PB] = din;
        m_ptr = (m_ptr + 1) % 256;
      end
      if (ld) m_cnt = BUSY; else if (m_cnt > 0) m_cnt--;
      m_oe = sel && !re_n;
      pwe = we_n; pre = re_n;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !rst && !done) begin
      chk(oe === m_oe, "R4 oe model", oe, m_oe);
      chk(rdy === (m_cnt == 0), "R8 rdy model", rdy, m_cnt == 0);
      if (m_oe) chk(dout === m_dout[7:0], "R4 dout model", dout, m_dout);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr_cyc(input logic c, input logic a, input logic [7:0] b);
    @(negedge clk);
    din = b; cle = c; ale = a; we_n = 1'b0;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask
  task automatic cmd(input logic [7:0] b);  wr_cyc(1'b1, 1'b0, b); endtask
  task automatic adr(input logic [7:0] b);  wr_cyc(1'b0, 1'b1, b); endtask
  task automatic dat(input logic [7:0] b);  wr_cyc(1'b0, 1'b0, b); endtask

  task automatic rd_chk(input int exp, input string req);
    @(negedge clk);
    re_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(dout === exp[7:0] && oe === 1'b1, req, dout, exp);
    re_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_rdy();
    while (!rdy) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1;
    @(negedge clk);
    chk(oe === 1'b0, "R11 reset oe", oe, 0);
    chk(rdy === 1'b1, "R11 reset rdy", rdy, 1);

    // R1 R2 R3: identification, first byte set
    cmd(8'h90); adr(8'h00);
    rd_chk('h01, "R2 id0"); rd_chk('hDC, "R3 id1 cfg0"); rd_chk('h90, "R3 id2 cfg0");
    rd_chk('h95, "R3 id3 cfg0"); rd_chk('h54, "R3 id4 cfg0"); rd_chk('h00, "R2 past end");

    // R5: status ignored in identification mode, allowed after 00h
    cmd(8'h90); adr(8'h00);
    rd_chk('h01, "R5 id0");
    cmd(8'h70);
    rd_chk('hDC, "R5 id continues after 70h");
    cmd(8'h00); cmd(8'h70);
    rd_chk('hC0, "R5 R7 status after dummy 00h");

    // R3: second byte set
    id_cfg = 1'b1;
    cmd(8'h90); adr(8'h00);
    rd_chk('h01, "R3 id0 cfg1"); rd_chk('hD3, "R3 id1 cfg1"); rd_chk('hD1, "R3 id2 cfg1");
    rd_chk('h95, "R3 id3 cfg1"); rd_chk('h58, "R3 id4 cfg1");
    id_cfg = 1'b0;

    // R6: parameter page across its 256-byte repeat
    cmd(8'hEC); adr(8'h00);
    for (int i = 0; i < 262; i++) rd_chk(exp_param(i), "R6 param byte");

    // R8: program, busy, read back
    cmd(8'h80); adr(8'h05);
    dat(8'hAA); dat(8'h55); dat(8'h3C);
    cmd(8'h10);
    chk(rdy === 1'b0, "R8 busy after confirm", rdy, 0);
    cmd(8'h70);
    rd_chk('h80, "R7 R8 status while busy");
    wait_rdy();
    rd_chk('hC0, "R7 status ready");
    cmd(8'h00); adr(8'h05); cmd(8'h30);
    rd_chk('hAA, "R8 readback 0"); rd_chk('h55, "R8 readback 1"); rd_chk('h3C, "R8 readback 2");

    // R12: commands ignored while busy
    cmd(8'h80); adr(8'h10); dat(8'h11); cmd(8'h10);
    cmd(8'h70); cmd(8'h90); adr(8'h00);
    rd_chk('h80, "R12 ident ignored while busy");
    wait_rdy();

    // R9: write protect
    wp_n = 1'b0;
    cmd(8'h80); adr(8'h05); dat(8'h77); cmd(8'h10);
    chk(rdy === 1'b1, "R9 no busy when protected", rdy, 1);
    cmd(8'h70);
    rd_chk('h41, "R9 R7 status shows fail");
    wp_n = 1'b1;
    cmd(8'h00); adr(8'h05); cmd(8'h30);
    rd_chk('hAA, "R9 buffer unchanged");
    wp_n = 1'b0;
    cmd(8'h60); adr(8'h00); cmd(8'hD0);
    chk(rdy === 1'b1, "R9 erase refused", rdy, 1);
    wp_n = 1'b1;

    // R10: erase clears fail
    cmd(8'h60); adr(8'h00); adr(8'h01); cmd(8'hD0);
    chk(rdy === 1'b0, "R10 erase busy", rdy, 0);
    wait_rdy();
    cmd(8'h70);
    rd_chk('hC0, "R10 fail cleared");

    // R1 R4: deselected strobes have no effect, no drive
    cs_n = 1'b1;
    cmd(8'h90); adr(8'h00);
    @(negedge clk); re_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(oe === 1'b0, "R4 no drive when deselected", oe, 0);
    re_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    rd_chk('hC0, "R1 deselected command ignored");

    // R11: FFh and reset return to idle
    cmd(8'h90); adr(8'h00); cmd(8'hFF);
    rd_chk('hFF, "R11 idle after FFh");
    cmd(8'h90); adr(8'h00);
    rd_chk('h01, "R11 id before reset");
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    chk(oe === 1'b0 && rdy === 1'b1, "R11 outputs after reset", {oe, rdy}, 1);
    rd_chk('hFF, "R11 idle after reset");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule